// File: doc/BRIEF.md
# Binary Lookup-Table Pulse Shaper

This block produces shaped baseband I/Q samples from a serial bit stream without any multipliers. It keeps a short history of received symbols for each rail and a phase counter that runs at the interpolated rate. Each clock, history and phase together form an address into a programmable waveform table, and the stored 16-bit signed entry becomes the output sample. Software computes the table contents off-line and loads them through a write port while the shaper is stopped.

Three shaping modes are available. Two are continuous-phase modes, a plain one and a Gaussian-filtered one, in which each symbol is a single bit and a window of the last four symbols selects the waveform. Both rails read their own table at the same address. The third is a linear quadrature mode in which each symbol arrives as an I bit followed by a Q bit. Each rail keeps its own longer history (parameter `QSPAN`, 6 to 12 symbols) and makes its own lookup, which works because the shaping is separable.

A control state machine has four states: `ST_IDLE` (stopped, table writable), `ST_CPM` (running in a single-bit mode), `ST_QI` (running quadrature, next bit is I) and `ST_QQ` (running quadrature, next bit is Q). Its transitions are: start (`ST_IDLE` to `ST_CPM` or `ST_QI` when `run` is high and the mode is valid), I-taken (`ST_QI` to `ST_QQ` on a serial bit), Q-taken (`ST_QQ` to `ST_QI` on a serial bit), and stop (any running state to `ST_IDLE` when `run` is low).

Top module: `bit_lut_shaper`

## Requirements
- R1: The mode is sampled only when `run` is seen high in `ST_IDLE`. The codes are 00 plain continuous-phase, 01 Gaussian continuous-phase, 10 quadrature and 11 reserved. With code 11 the block stays idle, and a change of `mode` while running has no effect on the outputs.
- R2: After reset, and in every cycle that follows a cycle in `ST_IDLE` or with `run` low, `out_vld` is 0 and both `out_i` and `out_q` are 0.
- R3: In `ST_IDLE`, `tbl_we` writes `tbl_data` to table entry `tbl_addr` of the I table when `tbl_rail`=0 and of the Q table when `tbl_rail`=1. A write requested while running is ignored.
- R4: While running, the phase starts at 0, rises by one each cycle, and wraps from 7 to 0. After a cycle with `sym_stb` high it is 0 again.
- R5: In the continuous-phase modes both tables are read at address {1'b0, g, h[3:0], phase}, where g is 1 for the Gaussian mode and h[3:0] holds the last four symbols with the newest in bit 0.
- R6: A serial bit (`ser_vld` high) is staged. `sym_stb` shifts the staged bit into the history at bit 0, using the staged value from before that cycle. The history changes at no other time, and a symbol older than four has no effect in the continuous-phase modes.
- R7: In quadrature mode the serial bits after the start alternate I, then Q, beginning with I. On `sym_stb` each rail shifts in its own staged bit. The I table is read at {hI, phase} and the Q table at {hQ, phase}, with each history `QSPAN` bits wide and the newest symbol in bit 0.
- R8: `out_i`/`out_q` show the table entries addressed by the history and phase of the previous cycle, and `out_vld` is high one cycle after each running cycle with `run` high.
- R9: Dropping `run` returns the block to `ST_IDLE` on the next edge and clears the histories, the staged bits and the phase, so a restart begins from an all-zero history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start/keep shaping; low stops and clears |
| mode | input | 2 | Shaping mode code, sampled at start |
| ser_bit | input | 1 | Serial data bit |
| ser_vld | input | 1 | Qualifies `ser_bit` |
| sym_stb | input | 1 | Symbol boundary strobe |
| tbl_we | input | 1 | Table write enable (idle only) |
| tbl_rail | input | 1 | Table select: 0 = I, 1 = Q |
| tbl_addr | input | QSPAN+PH_W | Table entry address |
| tbl_data | input | SW | Table entry value, two's complement |
| out_i | output | SW | I sample, two's complement |
| out_q | output | SW | Q sample, two's complement |
| out_vld | output | 1 | Sample valid |

## Verification
The assertions assume that `mode` is one of the four listed codes. They also assume that `sym_stb` and `ser_vld` have meaning only while `run` is high, and that a history shift never overlaps the clearing caused by a stop. The bench drives every input on the falling edge and keeps bits and strobes inside running periods. Table writes happen while idle, except for one deliberate write during running that checks R3. A cycle-level model built from the requirements predicts every output sample, covering strobes on back-to-back cycles, strobes in mid-phase, an unused reserved code and a mode change in mid-run.

// File: rtl/bls_pkg.sv
package bls_pkg;

    typedef enum logic [1:0] {
        MODE_MSK  = 2'b00,
        MODE_GMSK = 2'b01,
        MODE_QPSK = 2'b10,
        MODE_RSV  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_CPM  = 2'b01,
        ST_QI   = 2'b10,
        ST_QQ   = 2'b11
    } state_e;

endpackage

// File: rtl/bls_ctrl.sv
module bls_ctrl
    import bls_pkg::*;
#(
    parameter int PH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [1:0]      mode,
    input  logic            ser_vld,
    input  logic            sym_stb,
    output logic [PH_W-1:0] phase,
    output logic            cap_i,
    output logic            cap_q,
    output logic            shift,
    output logic            clr,
    output logic            gmsk_sel,
    output logic            qpsk_sel,
    output logic            wr_ok,
    output logic            out_vld
);

    state_e st, st_nx;
    mode_e  md, mode_q;
    logic   active;

    assign md = mode_e'(mode);

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (run) begin
                    unique case (md)
                        MODE_MSK, MODE_GMSK: st_nx = ST_CPM;
                        MODE_QPSK:           st_nx = ST_QI;
                        default:             st_nx = ST_IDLE;
                    endcase
                end
            end
            ST_CPM:  if (!run) st_nx = ST_IDLE;
            ST_QI:   if (!run) st_nx = ST_IDLE; else if (ser_vld) st_nx = ST_QQ;
            ST_QQ:   if (!run) st_nx = ST_IDLE; else if (ser_vld) st_nx = ST_QI;
        endcase
    end

    // state register and mode latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            mode_q <= MODE_MSK;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE && run) mode_q <= md;
        end
    end

    // per-state outputs
    always_comb begin
        active   = (st != ST_IDLE) && run;
        cap_i    = active && ser_vld && (st == ST_CPM || st == ST_QI);
        cap_q    = active && ser_vld && (st == ST_QQ);
        shift    = active && sym_stb;
        clr      = (st != ST_IDLE) && !run;
        gmsk_sel = (mode_q == MODE_GMSK);
        qpsk_sel = (st == ST_QI) || (st == ST_QQ);
        wr_ok    = (st == ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= active;
            if (!active || sym_stb) phase <= '0;
            else                    phase <= phase + 1'b1;
        end
    end

    // R1
    rsv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && run && md == MODE_RSV) |=> (st == ST_IDLE));

    // R4
    phase_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && sym_stb) |=> (phase == '0));

    // R4
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !sym_stb) |=> (phase == $past(phase) + 1'b1));

    // R7
    qpsk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_QI && run && ser_vld) |=> (st == ST_QQ));

endmodule

// File: rtl/bls_rail.sv
module bls_rail #(
    parameter int HW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          cap,
    input  logic          bit_in,
    input  logic          shift,
    output logic [HW-1:0] hist
);

    logic stg;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            stg  <= 1'b0;
            hist <= '0;
        end else begin
            if (shift) hist <= {hist[HW-2:0], stg};
            if (cap)   stg  <= bit_in;
        end
    end

    // R6
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !clr) |=> $stable(hist));

endmodule

// File: rtl/bls_table.sv
module bls_table #(
    parameter int AW = 9,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [SW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [SW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [SW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[raddr];
    end

endmodule

// File: rtl/bit_lut_shaper.sv
module bit_lut_shaper #(
    parameter int PH_W    = 3,
    parameter int QSPAN   = 6,
    parameter int CPM_WIN = 4,
    parameter int SW      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic [1:0]            mode,
    input  logic                  ser_bit,
    input  logic                  ser_vld,
    input  logic                  sym_stb,
    input  logic                  tbl_we,
    input  logic                  tbl_rail,
    input  logic [QSPAN+PH_W-1:0] tbl_addr,
    input  logic [SW-1:0]         tbl_data,
    output logic [SW-1:0]         out_i,
    output logic [SW-1:0]         out_q,
    output logic                  out_vld
);

    localparam int AW    = QSPAN + PH_W;
    localparam int PAD_W = AW - CPM_WIN - 1 - PH_W;

    logic [PH_W-1:0] phase;
    logic cap_i, cap_q, shift, clr, gmsk_sel, qpsk_sel, wr_ok;
    logic [AW-1:0]   addr_cpm;
    logic [QSPAN-1:0] hist  [2];
    logic [SW-1:0]    rdata [2];

    bls_ctrl #(.PH_W(PH_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .mode     (mode),
        .ser_vld  (ser_vld),
        .sym_stb  (sym_stb),
        .phase    (phase),
        .cap_i    (cap_i),
        .cap_q    (cap_q),
        .shift    (shift),
        .clr      (clr),
        .gmsk_sel (gmsk_sel),
        .qpsk_sel (qpsk_sel),
        .wr_ok    (wr_ok),
        .out_vld  (out_vld)
    );

    assign addr_cpm = {{PAD_W{1'b0}}, gmsk_sel, hist[0][CPM_WIN-1:0], phase};

    for (genvar r = 0; r < 2; r++) begin : g_rail
        logic          cap_r, shift_r, we_r;
        logic [AW-1:0] raddr;

        assign cap_r   = (r == 0) ? cap_i : cap_q;
        assign shift_r = (r == 0) ? shift : (shift && qpsk_sel);
        assign we_r    = tbl_we && wr_ok && (tbl_rail == r[0]);
        assign raddr   = qpsk_sel ? {hist[r], phase} : addr_cpm;

        bls_rail #(.HW(QSPAN)) u_rail (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .cap    (cap_r),
            .bit_in (ser_bit),
            .shift  (shift_r),
            .hist   (hist[r])
        );

        bls_table #(.AW(AW), .SW(SW)) u_tbl (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_r),
            .waddr (tbl_addr),
            .wdata (tbl_data),
            .raddr (raddr),
            .rdata (rdata[r])
        );
    end

    assign out_i = out_vld ? rdata[0] : '0;
    assign out_q = out_vld ? rdata[1] : '0;

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_i == '0 && out_q == '0));

    // R9
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (hist[0] == '0 && hist[1] == '0 && !out_vld));

endmodule

// File: tb/bit_lut_shaper_tb.sv
module bit_lut_shaper_tb;

    localparam int PH_W = 3, QSPAN = 6, AW = 9, DEPTH = 512;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, run, ser_bit, ser_vld, sym_stb, tbl_we, tbl_rail, out_vld;
    logic [1:0]    mode;
    logic [AW-1:0] tbl_addr;
    logic [15:0]   tbl_data, out_i, out_q;

    bit_lut_shaper u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .mode(mode),
        .ser_bit(ser_bit), .ser_vld(ser_vld), .sym_stb(sym_stb),
        .tbl_we(tbl_we), .tbl_rail(tbl_rail), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .out_i(out_i), .out_q(out_q), .out_vld(out_vld)
    );

    int n_run = 0, n_fail = 0;

    // model of the requirements
    logic [15:0] mi [DEPTH];
    logic [15:0] mq [DEPTH];
    int          ms = 0;          // 0 idle, 1 cpm, 2 expect I, 3 expect Q
    logic [1:0]  mmode = 2'b00;
    logic [2:0]  mph = 3'd0;
    logic [5:0]  mhi = 6'd0, mhq = 6'd0;
    logic        msi = 1'b0, msq = 1'b0;

    function automatic logic [AW-1:0] maddr(input int rail);
        if (ms == 1) return {1'b0, mmode[0], mhi[3:0], mph};
        return {(rail == 1) ? mhq : mhi, mph};
    endfunction

    task automatic cyc(input logic r, input logic [1:0] md, input logic v, input logic b,
                       input logic s, input logic we, input logic wr,
                       input logic [AW-1:0] wa, input logic [15:0] wd, input string tag);
        logic act, ev;
        logic [15:0] ei, eq;
        run = r; mode = md; ser_vld = v; ser_bit = b; sym_stb = s;
        tbl_we = we; tbl_rail = wr; tbl_addr = wa; tbl_data = wd;
        act = (ms != 0) && r;
        ev = act;
        ei = act ? mi[maddr(0)] : 16'h0;
        eq = act ? mq[maddr(1)] : 16'h0;
        if (ms == 0) begin
            if (we) begin
                if (wr) mq[wa] = wd; else mi[wa] = wd;
            end
            if (r && md != 2'b11) begin
                ms = (md == 2'b10) ? 2 : 1; mmode = md; mph = 3'd0;
            end
        end else if (!r) begin
            ms = 0; mph = 3'd0; mhi = 6'd0; mhq = 6'd0; msi = 1'b0; msq = 1'b0;
        end else begin
            mph = s ? 3'd0 : mph + 3'd1;
            if (s) begin
                mhi = {mhi[4:0], msi};
                if (ms != 1) mhq = {mhq[4:0], msq};
            end
            if (v) begin
                if (ms == 3) begin msq = b; ms = 2; end
                else begin msi = b; if (ms == 2) ms = 3; end
            end
        end
        @(posedge clk);
        @(negedge clk);
        n_run++;
        if ({out_vld, out_i, out_q} !== {ev, ei, eq}) begin
            n_fail++;
            $display("FAIL %s: got vld=%0b i=%h q=%h, expected vld=%0b i=%h q=%h",
                     tag, out_vld, out_i, out_q, ev, ei, eq);
        end
    endtask

    task automatic tick(input logic r, input logic [1:0] md, input string tag);
        cyc(r, md, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 16'h0, tag);
    endtask

    task automatic sym1(input logic [1:0] md, input logic b, input string tag);
        cyc(1'b1, md, 1'b1, b, 1'b0, 1'b0, 1'b0, '0, 16'h0, tag);
        tick(1'b1, md, tag);
        cyc(1'b1, md, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 16'h0, tag);
    endtask

    task automatic t_reset();
        n_run++;
        if ({out_vld, out_i, out_q} !== 33'h0) begin
            n_fail++;
            $display("FAIL R2: got vld=%0b i=%h q=%h, expected all zero", out_vld, out_i, out_q);
        end
    endtask

    task automatic t_load();
        for (int a = 0; a < DEPTH; a++)
            cyc(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, AW'(a), 16'(a * 37 + 5), "R3");
        for (int a = 0; a < DEPTH; a++)
            cyc(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, AW'(a), ~16'(a * 11) + 16'h0100, "R3");
    endtask

    task automatic t_cpm(input logic [1:0] md, input logic [7:0] pat, input string tag);
        tick(1'b1, md, "R1");
        for (int k = 0; k < 11; k++) tick(1'b1, md, "R4");
        for (int k = 0; k < 8; k++) sym1(md, pat[k], tag);
        for (int k = 0; k < 3; k++) tick(1'b1, 2'b10, "R1");       // mode change mid-run
        cyc(1'b1, md, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, 16'h0, "R6"); // strobe + new bit
        cyc(1'b1, md, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 16'h0, "R6"); // back-to-back strobe
        for (int k = 0; k < 4; k++) tick(1'b1, md, "R8");
        tick(1'b0, md, "R9");
        tick(1'b0, md, "R2");
    endtask

    task automatic t_qpsk();
        logic [15:0] pat = 16'b1011_0010_1110_0101;
        tick(1'b1, 2'b10, "R1");
        for (int k = 0; k < 8; k++) begin
            cyc(1'b1, 2'b10, 1'b1, pat[2*k],   1'b0, 1'b0, 1'b0, '0, 16'h0, "R7");
            cyc(1'b1, 2'b10, 1'b1, pat[2*k+1], 1'b0, 1'b0, 1'b0, '0, 16'h0, "R7");
            tick(1'b1, 2'b00, "R7");
            cyc(1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 16'h0, "R7");
        end
        for (int k = 0; k < 9; k++) tick(1'b1, 2'b10, "R4");
        tick(1'b0, 2'b10, "R9");
    endtask

    task automatic t_rsv();
        for (int k = 0; k < 4; k++) tick(1'b1, 2'b11, "R1");
        tick(1'b0, 2'b00, "R2");
    endtask

    task automatic t_wr_run();
        tick(1'b1, 2'b00, "R3");
        cyc(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 9'd5, 16'h7777, "R3");
        cyc(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 9'd6, 16'h6666, "R3");
        for (int k = 0; k < 8; k++) tick(1'b1, 2'b00, "R3");
        for (int k = 0; k < 5; k++) sym1(2'b00, 1'b1, "R5");
        tick(1'b0, 2'b00, "R9");
        tick(1'b1, 2'b00, "R9");
        for (int k = 0; k < 8; k++) tick(1'b1, 2'b00, "R9");
        tick(1'b0, 2'b00, "R9");
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; run = 1'b0; mode = 2'b00; ser_bit = 1'b0; ser_vld = 1'b0;
        sym_stb = 1'b0; tbl_we = 1'b0; tbl_rail = 1'b0; tbl_addr = '0; tbl_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_cpm(2'b00, 8'b1011_0110, "R5");
        t_cpm(2'b01, 8'b0110_1101, "R5");
        t_qpsk();
        t_rsv();
        t_wr_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule